// File: doc/BRIEF.md
# Byte Instruction Buffer With Dispatch

This block sits between the memory fetch path and the microsequencer of a bytecode engine. It keeps up to three opcode bytes: a front byte that is always the next one to leave, and two staging bytes behind it. A 2-bit fill pointer tracks how many bytes are held. The microcode refills it with 16-bit words and reads bytes or nibbles from the front. It can force the pointer to a fixed fill level, and it can ask for a dispatch on the front byte.

A dispatch has one of two results. On success, the front byte is recorded and merged into the next microinstruction address: its high nibble replaces one address field and its low nibble is ORed into the field below. The byte is then consumed. If the buffer is not full, or a bytecode interrupt is pending, the dispatch becomes a trap instead. A 4-bit code is written into the top address field and the buffer is left as it was. The modifier is held in a register and applied to the base address of the following microinstruction. In that cycle, a pending error trap overrides a pending refill trap.

Every read of the front byte while the buffer is empty raises an error. If that read happened in the first cycle of the three-cycle microcycle group, the block also asks for the memory data write of the next cycle to be cancelled.

Top module: `ibuf_dispatch`

## Requirements
- R1: After reset the fill state is empty (0), the front byte is 0, `mdr_cancel_o` is 0, and `next_addr_o` equals `base_addr_i`.
- R2: Op 2 (take) on a non-empty buffer returns the front byte on `rd_data_o` in the same cycle. The new front is staging byte 0 when the state's bit 0 is 0, and staging byte 1 otherwise. The state steps full(2) to word(3) to byte(1) to empty(0). A take on an empty buffer changes neither the state nor the front.
- R3: Op 1 (load) without `force_i` always writes the word's low byte into staging byte 1. If the buffer was empty, the high byte becomes the front and the state becomes word(3). Otherwise the high byte goes to staging byte 0 and the state becomes full(2).
- R4: Op 1 with `force_i` on an empty buffer puts the low byte in the front, discards the high byte and sets the state to byte(1). On a non-empty buffer it writes the high byte to staging byte 0 and the low byte to staging byte 1, sets the state to full(2) and leaves the front unchanged.
- R5: Ops 2, 3, 4 and 5 on an empty buffer assert `empty_err_o` in the same cycle and drive `rd_data_o` to 0. `empty_err_o` is 0 in every other case.
- R6: `mdr_cancel_o` is 1 in the cycle after an empty-read error that occurred while `in_c1_i` was 1, and 0 otherwise.
- R7: Op 3 (peek) returns the front byte. Op 4 returns the front's bits [3:0] and op 5 returns its bits [7:4], each zero-extended. None of the three changes the state or the front. Ops 0 and 9 to 15 drive `rd_data_o` to 0.
- R8: Op 8 (dispatch) without `force_i` traps when the state is not full or `irq_pend_i` is 1. With no interrupt, the code is 4 when empty and 5 otherwise. With an interrupt, the code is 6 when empty or full and 7 otherwise. In the next cycle the code replaces `next_addr_o[11:8]`. The state and the front are unchanged.
- R9: A non-trapping dispatch takes effect in the next cycle. There, `next_addr_o` is the base with bits [7:4] replaced by the front's high nibble and the front's low nibble ORed into bits [3:0]. The byte is consumed as in R2 when the buffer is not empty.
- R10: Op 8 with `force_i` never traps, whatever the state and `irq_pend_i`.
- R11: Op 6 sets the state to byte(1) and the front to staging byte 1, unless the state is already byte. Op 7 sets the state to word(3) and the front to staging byte 0, unless the state is already word.
- R12: When a trap modifier is being applied and `err_pend_i` is 1, `next_addr_o` equals `base_addr_i` unmodified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code for this cycle |
| force_i | input | 1 | Force-to-byte modifier for load, non-trapping modifier for dispatch |
| word_i | input | 16 | Word for a load |
| in_c1_i | input | 1 | Current cycle is the first of the microcycle group |
| irq_pend_i | input | 1 | Bytecode interrupt request pending |
| err_pend_i | input | 1 | Error trap pending |
| base_addr_i | input | 12 | Base next address of the current microinstruction |
| rd_data_o | output | 8 | Byte or nibble read result |
| empty_err_o | output | 1 | Read attempted on an empty buffer |
| mdr_cancel_o | output | 1 | Cancel this cycle's memory data write |
| state_o | output | 2 | Fill state |
| front_o | output | 8 | Front byte |
| next_addr_o | output | 12 | Base address merged with the pending modifier |

## Verification
A modifier produced by one dispatch is merged into the address in the same cycle that the next operation runs. That next operation can be a load, a read, a second dispatch or a pointer load, and the pending-error input can arrive in that cycle too. The bench provokes this by issuing dispatches back to back, a dispatch followed at once by a load, and a trap followed by `err_pend_i`. A scoreboard model judges each cycle's merged address and the updated buffer state separately, so a merge that leaks into the buffer update, or the reverse, is caught. A long pseudo-random operation stream then mixes all of these overlaps.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_BYTE  = 2'd1,
        FS_FULL  = 2'd2,
        FS_WORD  = 2'd3
    } fill_e;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_LOAD  = 4'd1,
        OP_TAKE  = 4'd2,
        OP_PEEK  = 4'd3,
        OP_LONIB = 4'd4,
        OP_HINIB = 4'd5,
        OP_PTR1  = 4'd6,
        OP_PTR0  = 4'd7,
        OP_DISP  = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        MK_NONE = 2'd0,
        MK_DISP = 2'd1,
        MK_TRAP = 2'd2
    } mod_e;

    // Drain order when one byte leaves the buffer.
    function automatic fill_e fill_step(input fill_e s);
        case (s)
            FS_FULL: fill_step = FS_WORD;
            FS_WORD: fill_step = FS_BYTE;
            default: fill_step = FS_EMPTY;
        endcase
    endfunction

endpackage

// File: rtl/ibuf_trap_sel.sv
module ibuf_trap_sel
    import ibuf_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  fill_e              state_i,
    input  logic               irq_i,
    input  logic               force_i,
    output logic               trap_o,
    output logic [CODE_W-1:0]  code_o
);
    localparam logic [CODE_W-1:0] C_REFILL_EMPTY = CODE_W'(4);
    localparam logic [CODE_W-1:0] C_REFILL_PART  = CODE_W'(5);
    localparam logic [CODE_W-1:0] C_IRQ_EDGE     = CODE_W'(6);
    localparam logic [CODE_W-1:0] C_IRQ_PART     = CODE_W'(7);

    logic is_empty;
    logic is_full;

    always_comb begin
        is_empty = (state_i == FS_EMPTY);
        is_full  = (state_i == FS_FULL);
        trap_o   = !force_i && (!is_full || irq_i);
        if (irq_i) begin
            code_o = (is_empty || is_full) ? C_IRQ_EDGE : C_IRQ_PART;
        end else begin
            code_o = is_empty ? C_REFILL_EMPTY : C_REFILL_PART;
        end
    end

endmodule

// File: rtl/ibuf_rd_mux.sv
module ibuf_rd_mux
    import ibuf_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  op_e                op_i,
    input  fill_e              state_i,
    input  logic [BYTE_W-1:0]  front_i,
    output logic [BYTE_W-1:0]  rd_data_o,
    output logic               empty_err_o
);
    localparam int NIB_W = BYTE_W / 2;

    logic is_read;

    always_comb begin
        is_read = (op_i == OP_TAKE) || (op_i == OP_PEEK) ||
                  (op_i == OP_LONIB) || (op_i == OP_HINIB);
        empty_err_o = is_read && (state_i == FS_EMPTY);
        rd_data_o   = '0;
        if (is_read && !empty_err_o) begin
            case (op_i)
                OP_LONIB: rd_data_o = {{(BYTE_W-NIB_W){1'b0}}, front_i[NIB_W-1:0]};
                OP_HINIB: rd_data_o = {{(BYTE_W-NIB_W){1'b0}}, front_i[BYTE_W-1:NIB_W]};
                default:  rd_data_o = front_i;
            endcase
        end
    end

endmodule

// File: rtl/ibuf_na_merge.sv
module ibuf_na_merge
    import ibuf_pkg::*;
#(
    parameter int NA_W   = 12,
    parameter int BYTE_W = 8,
    parameter int CODE_W = 4
) (
    input  logic [NA_W-1:0]  base_i,
    input  mod_e             kind_i,
    input  logic [NA_W-1:0]  val_i,
    input  logic             err_pend_i,
    output logic [NA_W-1:0]  next_addr_o
);
    localparam int NIB_W = BYTE_W / 2;
    // Field overwritten by the front's high nibble.
    localparam logic [NA_W-1:0] HI_NIB_MASK =
        NA_W'(((1 << BYTE_W) - 1) ^ ((1 << NIB_W) - 1));
    // Field overwritten by a trap code.
    localparam logic [NA_W-1:0] TOP_MASK =
        NA_W'(((1 << CODE_W) - 1) << (NA_W - CODE_W));

    always_comb begin
        case (kind_i)
            MK_DISP: next_addr_o = (base_i & ~HI_NIB_MASK) | val_i;
            MK_TRAP: next_addr_o = err_pend_i ? base_i
                                              : ((base_i & ~TOP_MASK) | val_i);
            default: next_addr_o = base_i;
        endcase
    end

endmodule

// File: rtl/ibuf_dispatch.sv
module ibuf_dispatch
    import ibuf_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NA_W   = 12,
    parameter int CODE_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           op_i,
    input  logic                 force_i,
    input  logic [2*BYTE_W-1:0]  word_i,
    input  logic                 in_c1_i,
    input  logic                 irq_pend_i,
    input  logic                 err_pend_i,
    input  logic [NA_W-1:0]      base_addr_i,
    output logic [BYTE_W-1:0]    rd_data_o,
    output logic                 empty_err_o,
    output logic                 mdr_cancel_o,
    output logic [1:0]           state_o,
    output logic [BYTE_W-1:0]    front_o,
    output logic [NA_W-1:0]      next_addr_o
);
    localparam int NSTAGE = 2;

    typedef struct packed {
        fill_e                          state;
        logic [BYTE_W-1:0]              front;
        logic [NSTAGE-1:0][BYTE_W-1:0]  stage;
        mod_e                           kind;
        logic [NA_W-1:0]                val;
        logic                           cancel;
    } ibuf_t;

    ibuf_t cur_q;
    ibuf_t nxt_d;

    op_e               op;
    logic              trap;
    logic [CODE_W-1:0] code;
    logic [BYTE_W-1:0] w_hi;
    logic [BYTE_W-1:0] w_lo;

    assign op   = op_e'(op_i);
    assign w_hi = word_i[2*BYTE_W-1:BYTE_W];
    assign w_lo = word_i[BYTE_W-1:0];

    ibuf_trap_sel #(.CODE_W(CODE_W)) u_trap (
        .state_i (cur_q.state),
        .irq_i   (irq_pend_i),
        .force_i (force_i),
        .trap_o  (trap),
        .code_o  (code)
    );

    ibuf_rd_mux #(.BYTE_W(BYTE_W)) u_rd (
        .op_i        (op),
        .state_i     (cur_q.state),
        .front_i     (cur_q.front),
        .rd_data_o   (rd_data_o),
        .empty_err_o (empty_err_o)
    );

    ibuf_na_merge #(.NA_W(NA_W), .BYTE_W(BYTE_W), .CODE_W(CODE_W)) u_na (
        .base_i      (base_addr_i),
        .kind_i      (cur_q.kind),
        .val_i       (cur_q.val),
        .err_pend_i  (err_pend_i),
        .next_addr_o (next_addr_o)
    );

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.kind   = MK_NONE;
        nxt_d.val    = '0;
        nxt_d.cancel = empty_err_o && in_c1_i;
        case (op)
            OP_LOAD: begin
                if (force_i) begin
                    if (cur_q.state == FS_EMPTY) begin
                        nxt_d.front = w_lo;
                        nxt_d.state = FS_BYTE;
                    end else begin
                        nxt_d.stage[0] = w_hi;
                        nxt_d.stage[1] = w_lo;
                        nxt_d.state    = FS_FULL;
                    end
                end else begin
                    nxt_d.stage[1] = w_lo;
                    if (cur_q.state == FS_EMPTY) begin
                        nxt_d.front = w_hi;
                        nxt_d.state = FS_WORD;
                    end else begin
                        nxt_d.stage[0] = w_hi;
                        nxt_d.state    = FS_FULL;
                    end
                end
            end
            OP_TAKE: begin
                if (cur_q.state != FS_EMPTY) begin
                    nxt_d.front = cur_q.stage[cur_q.state[0]];
                    nxt_d.state = fill_step(cur_q.state);
                end
            end
            OP_PTR1: begin
                if (cur_q.state != FS_BYTE) begin
                    nxt_d.state = FS_BYTE;
                    nxt_d.front = cur_q.stage[1];
                end
            end
            OP_PTR0: begin
                if (cur_q.state != FS_WORD) begin
                    nxt_d.state = FS_WORD;
                    nxt_d.front = cur_q.stage[0];
                end
            end
            OP_DISP: begin
                if (trap) begin
                    nxt_d.kind = MK_TRAP;
                    nxt_d.val  = NA_W'(code) << (NA_W - CODE_W);
                end else begin
                    nxt_d.kind = MK_DISP;
                    nxt_d.val  = NA_W'(cur_q.front);
                    if (cur_q.state != FS_EMPTY) begin
                        nxt_d.front = cur_q.stage[cur_q.state[0]];
                        nxt_d.state = fill_step(cur_q.state);
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mdr_cancel_o = cur_q.cancel;
    assign state_o      = cur_q.state;
    assign front_o      = cur_q.front;

endmodule

// File: rtl/ibuf_dispatch_chk.sv
module ibuf_dispatch_chk
    import ibuf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] op_i,
    input logic       force_i,
    input logic       in_c1_i,
    input logic       irq_pend_i,
    input logic       empty_err_o,
    input logic       mdr_cancel_o,
    input logic [1:0] state_o
);
    // R6
    cancel_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_err_o && in_c1_i) |=> mdr_cancel_o);

    // R5
    err_only_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty_err_o |-> (state_o == 2'd0));

    // R2
    empty_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_TAKE && state_o == 2'd0) |=> (state_o == 2'd0));

    // R11
    ptr0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_PTR0) |=> (state_o == 2'd3));

    // R11
    ptr1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_PTR1) |=> (state_o == 2'd1));

    // R8
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_DISP && !force_i && (state_o != 2'd2 || irq_pend_i))
        |=> $stable(state_o));

    // R4
    force_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LOAD && force_i && state_o == 2'd0) |=> (state_o == 2'd1));

    // R3
    plain_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LOAD && state_o != 2'd0) |=> (state_o == 2'd2));

endmodule

bind ibuf_dispatch ibuf_dispatch_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_i         (op_i),
    .force_i      (force_i),
    .in_c1_i      (in_c1_i),
    .irq_pend_i   (irq_pend_i),
    .empty_err_o  (empty_err_o),
    .mdr_cancel_o (mdr_cancel_o),
    .state_o      (state_o)
);

// File: tb/ibuf_dispatch_test.sv
module ibuf_dispatch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic        force_i = 1'b0;
    logic [15:0] word_i = 16'h0;
    logic        in_c1_i = 1'b0;
    logic        irq_pend_i = 1'b0;
    logic        err_pend_i = 1'b0;
    logic [11:0] base_addr_i = 12'h5A5;
    logic [7:0]  rd_data_o;
    logic        empty_err_o;
    logic        mdr_cancel_o;
    logic [1:0]  state_o;
    logic [7:0]  front_o;
    logic [11:0] next_addr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ibuf_dispatch uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .force_i(force_i),
        .word_i(word_i), .in_c1_i(in_c1_i), .irq_pend_i(irq_pend_i),
        .err_pend_i(err_pend_i), .base_addr_i(base_addr_i),
        .rd_data_o(rd_data_o), .empty_err_o(empty_err_o),
        .mdr_cancel_o(mdr_cancel_o), .state_o(state_o),
        .front_o(front_o), .next_addr_o(next_addr_o)
    );

    typedef struct {
        string       tag;
        logic [7:0]  rd;
        logic        err;
        logic [11:0] na;
        logic [1:0]  state;
        logic [7:0]  front;
        logic        cancel;
    } exp_t;

    exp_t sb[$];

    // Reference model state
    logic [1:0]  m_state = 2'd0;
    logic [7:0]  m_front = 8'h0;
    logic [7:0]  m_s0 = 8'h0;
    logic [7:0]  m_s1 = 8'h0;
    logic [1:0]  m_kind = 2'd0;   // 0 none, 1 dispatch, 2 trap
    logic [7:0]  m_byte = 8'h0;
    logic [3:0]  m_code = 4'h0;

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] m_step(input logic [1:0] s);
        case (s)
            2'd2: m_step = 2'd3;
            2'd3: m_step = 2'd1;
            default: m_step = 2'd0;
        endcase
    endfunction

    task automatic consume();
        if (m_state != 2'd0) begin
            m_front = m_state[0] ? m_s1 : m_s0;
            m_state = m_step(m_state);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic frc,
                         input logic [15:0] w, input logic c1,
                         input logic irq, input logic err,
                         input logic [11:0] base, input string tag);
        exp_t e;
        logic emp;
        logic trap;
        @(negedge clk);
        op_i = op; force_i = frc; word_i = w; in_c1_i = c1;
        irq_pend_i = irq; err_pend_i = err; base_addr_i = base;
        emp = (m_state == 2'd0);
        e.tag = tag;
        case (m_kind)
            2'd1: e.na = (base & 12'hF0F) | {4'h0, m_byte};
            2'd2: e.na = err ? base : ((base & 12'h0FF) | {m_code, 8'h00});
            default: e.na = base;
        endcase
        e.err = (op >= 4'd2 && op <= 4'd5) && emp;
        if (e.err) e.rd = 8'h0;
        else if (op == 4'd2 || op == 4'd3) e.rd = m_front;
        else if (op == 4'd4) e.rd = {4'h0, m_front[3:0]};
        else if (op == 4'd5) e.rd = {4'h0, m_front[7:4]};
        else e.rd = 8'h0;
        m_kind = 2'd0;
        case (op)
            4'd1: begin
                if (frc) begin
                    if (emp) begin m_front = w[7:0]; m_state = 2'd1; end
                    else begin m_s0 = w[15:8]; m_s1 = w[7:0]; m_state = 2'd2; end
                end else begin
                    m_s1 = w[7:0];
                    if (emp) begin m_front = w[15:8]; m_state = 2'd3; end
                    else begin m_s0 = w[15:8]; m_state = 2'd2; end
                end
            end
            4'd2: consume();
            4'd6: if (m_state != 2'd1) begin m_state = 2'd1; m_front = m_s1; end
            4'd7: if (m_state != 2'd3) begin m_state = 2'd3; m_front = m_s0; end
            4'd8: begin
                trap = !frc && (m_state != 2'd2 || irq);
                if (trap) begin
                    m_kind = 2'd2;
                    if (irq) m_code = (emp || m_state == 2'd2) ? 4'd6 : 4'd7;
                    else     m_code = emp ? 4'd4 : 4'd5;
                end else begin
                    m_kind = 2'd1;
                    m_byte = m_front;
                    consume();
                end
            end
            default: ;
        endcase
        e.state  = m_state;
        e.front  = m_front;
        e.cancel = e.err && c1;
        sb.push_back(e);
    endtask

    // Monitor: combinational outputs just before the edge, registered after it.
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb[0];
                chk(e.tag, "rd_data", 16'(rd_data_o), 16'(e.rd));
                chk(e.tag, "empty_err", 16'(empty_err_o), 16'(e.err));
                chk(e.tag, "next_addr", 16'(next_addr_o), 16'(e.na));
                @(posedge clk);
                #1;
                e = sb.pop_front();
                chk(e.tag, "state", 16'(state_o), 16'(e.state));
                chk(e.tag, "front", 16'(front_o), 16'(e.front));
                chk(e.tag, "mdr_cancel", 16'(mdr_cancel_o), 16'(e.cancel));
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog timeout");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "state", 16'(state_o), 16'd0);
        chk("R1", "front", 16'(front_o), 16'h0);
        chk("R1", "mdr_cancel", 16'(mdr_cancel_o), 16'd0);
        chk("R1", "next_addr", 16'(next_addr_o), 16'h5A5);

        // R5 R6: empty reads, in c1 and outside it
        drive(4'd3, 0, 16'h0, 1, 0, 0, 12'h111, "R5_R6");
        drive(4'd4, 0, 16'h0, 0, 0, 0, 12'h111, "R6");
        drive(4'd5, 0, 16'h0, 1, 0, 0, 12'h111, "R5");
        drive(4'd2, 0, 16'h0, 0, 0, 0, 12'h111, "R2");
        // R3 plain loads
        drive(4'd1, 0, 16'hABCD, 0, 0, 0, 12'h000, "R3");
        drive(4'd1, 0, 16'h1234, 0, 0, 0, 12'h000, "R3");
        // R7 non-consuming reads
        drive(4'd3, 0, 16'h0, 1, 0, 0, 12'h000, "R7");
        drive(4'd4, 0, 16'h0, 0, 0, 0, 12'h000, "R7");
        drive(4'd5, 0, 16'h0, 0, 0, 0, 12'h000, "R7");
        drive(4'd0, 0, 16'h0, 0, 0, 0, 12'h000, "R7");
        // R2 drain sequence
        drive(4'd2, 0, 16'h0, 0, 0, 0, 12'h000, "R2");
        drive(4'd2, 0, 16'h0, 0, 0, 0, 12'h000, "R2");
        drive(4'd2, 0, 16'h0, 0, 0, 0, 12'h000, "R2");
        drive(4'd2, 0, 16'h0, 1, 0, 0, 12'h000, "R2_R6");
        // R4 forced loads
        drive(4'd1, 1, 16'h5678, 0, 0, 0, 12'h000, "R4");
        drive(4'd1, 1, 16'h9ABC, 0, 0, 0, 12'h000, "R4");
        // R9 successful dispatch, merged while a second dispatch traps
        drive(4'd8, 0, 16'h0, 0, 0, 0, 12'h000, "R9");
        drive(4'd8, 0, 16'h0, 0, 0, 0, 12'h3A5, "R9_R8");
        drive(4'd8, 0, 16'h0, 0, 1, 0, 12'h0C3, "R8");
        // R12 pending error drops the trap
        drive(4'd0, 0, 16'h0, 0, 0, 1, 12'h0C3, "R12");
        // R11 pointer loads
        drive(4'd6, 0, 16'h0, 0, 0, 0, 12'h000, "R11");
        drive(4'd6, 0, 16'h0, 0, 0, 0, 12'h000, "R11");
        drive(4'd7, 0, 16'h0, 0, 0, 0, 12'h000, "R11");
        drive(4'd7, 0, 16'h0, 0, 0, 0, 12'h000, "R11");
        // R8 full with interrupt, then R10 forced dispatch
        drive(4'd1, 0, 16'hC3D4, 0, 0, 0, 12'h000, "R3");
        drive(4'd8, 0, 16'h0, 0, 1, 0, 12'h000, "R8");
        drive(4'd8, 1, 16'h0, 0, 1, 0, 12'h777, "R10");
        drive(4'd6, 0, 16'h0, 0, 0, 0, 12'h0F0, "R10_R11");
        drive(4'd8, 1, 16'h0, 0, 0, 0, 12'h000, "R10");
        // Empty dispatch traps, then a load in the merge cycle
        drive(4'd8, 0, 16'h0, 0, 0, 0, 12'h0FF, "R10_R8");
        drive(4'd8, 0, 16'h0, 0, 1, 0, 12'h0AA, "R8");
        drive(4'd1, 0, 16'hEE11, 0, 0, 0, 12'h055, "R8_R3");
        drive(4'd0, 0, 16'h0, 0, 0, 0, 12'h000, "R8");

        // Mixed pseudo-random stream
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(4'(lfsr[3:0] % 10), lfsr[4], {lfsr[7:0], lfsr[15:8]},
                  lfsr[5], lfsr[6] & lfsr[9], lfsr[11] & lfsr[8],
                  {lfsr[11:0]}, "MIX");
        end
        drive(4'd0, 0, 16'h0, 0, 0, 0, 12'h000, "MIX");
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule